// File: doc/BRIEF.md
# Per-Link Sequence Number Integrity Checker

This block decides, frame by frame, whether a received frame's 8-bit sequence number follows the order its sender is allowed to use. The receive path upstream has already parsed the frame. It presents one descriptor per cycle: a strobe, the virtual-link index, the network the frame arrived on (A or B) and the sequence number. One clock later the block returns a single accept or drop verdict, and it keeps a saturating count of the frames it has dropped.

A separate history is kept for every link on every network. Each history is a last-accepted value and a flag that says whether the history has been loaded. Senders count 1 through 255 and then continue at 1, so 0 never appears in the normal count. A 0 means that the sender has restarted. The receiver tolerates one missing frame, so a step of one or two along this wrapped count is legal. Two enable vectors, one per network, select which links are checked. On a network where a link is not checked, its frames pass through unchecked.

Top module: `seqchk`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `out_valid`, `out_accept` and `out_drop` are low, `drop_count` is 0, and every history is empty.
- R2: A descriptor sampled with `in_valid` high gives `out_valid` high on the next cycle, with exactly one of `out_accept` and `out_drop` high. A cycle with `in_valid` low gives all three outputs low on the next cycle.
- R3: When checking is enabled, the first frame seen on a link/network pair with an empty history is accepted whatever its number, and it loads the history.
- R4: When checking is enabled and the history holds P, a frame is accepted when its number is one or two steps after P. The successor of P is P+1, except that the successor of 255 is 1. From P=254 the accepted numbers are 255 and 1. From P=255 they are 1 and 2. From P=0 they are 1 and 2. An accepted frame makes its number the new history.
- R5: When checking is enabled, a frame numbered 0 is always accepted, and it sets the history to 0.
- R6: When checking is enabled, a frame that falls under neither R3, R4 nor R5 is dropped, and its history keeps its previous value.
- R7: Each dropped frame adds one to `drop_count`, and the count stays at its all-ones value once it gets there. `drop_count` changes in the same cycle that `out_drop` is reported, and it changes at no other time.
- R8: Bit L of `chk_en_a` (network A, `in_net`=0) or of `chk_en_b` (network B, `in_net`=1) enables checking for link L. When checking is disabled, the frame is accepted, and neither its history nor the drop count changes.
- R9: The history of each link/network pair is independent of all the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor strobe |
| in_link | input | LINK_W | Virtual-link index |
| in_net | input | 1 | Network: 0 = A, 1 = B |
| in_seq | input | 8 | Frame sequence number |
| chk_en_a | input | NUM_LINKS | Per-link check enable, network A |
| chk_en_b | input | NUM_LINKS | Per-link check enable, network B |
| out_valid | output | 1 | Verdict strobe, one cycle after `in_valid` |
| out_accept | output | 1 | Frame accepted |
| out_drop | output | 1 | Frame dropped |
| drop_count | output | CNT_W | Saturating count of dropped frames |

## Verification
The assertions assume that `in_link` is always below `NUM_LINKS` while `in_valid` is high. They also assume that the enable vectors change only between descriptors and never in the same cycle as one. The bench drives every input on the falling clock edge and uses only link indices inside the configured range. It changes the enables only in cycles where the strobe is low. It loads each of the 16 link/network histories with a value P after a reset, then presents one candidate per history. Over the run it covers every pair of P and candidate number.

// File: rtl/seqchk.sv
module seqchk #(
  parameter int NUM_LINKS = 8,
  parameter int CNT_W     = 16,
  localparam int LINK_W   = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
  localparam int SLOTS    = NUM_LINKS * 2,
  localparam int SLOT_W   = LINK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [LINK_W-1:0] in_link,
  input  logic              in_net,
  input  logic [7:0]        in_seq,
  input  logic [NUM_LINKS-1:0] chk_en_a,
  input  logic [NUM_LINKS-1:0] chk_en_b,
  output logic              out_valid,
  output logic              out_accept,
  output logic              out_drop,
  output logic [CNT_W-1:0]  drop_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [7:0]       last_q [SLOTS];
  logic [SLOTS-1:0] seen_q;

  logic [SLOT_W-1:0] slot;
  logic [7:0]        prev, step1, step2;
  logic              enabled, verdict_ok, drop_now, load_hist;

  assign slot  = {in_link, in_net};
  assign prev  = last_q[slot];
  assign step1 = (prev == 8'hFF) ? 8'h01 : prev + 8'h01;
  assign step2 = (prev == 8'hFF) ? 8'h02 :
                 (prev == 8'hFE) ? 8'h01 : prev + 8'h02;

  assign enabled    = in_net ? chk_en_b[in_link] : chk_en_a[in_link];
  assign verdict_ok = !enabled || !seen_q[slot] || (in_seq == 8'h00) ||
                      (in_seq == step1) || (in_seq == step2);
  assign drop_now   = in_valid && !verdict_ok;
  assign load_hist  = in_valid && enabled && verdict_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q     <= '0;
      out_valid  <= 1'b0;
      out_accept <= 1'b0;
      out_drop   <= 1'b0;
      drop_count <= '0;
    end else begin
      out_valid  <= in_valid;
      out_accept <= in_valid && verdict_ok;
      out_drop   <= drop_now;
      if (drop_now && drop_count != CNT_MAX)
        drop_count <= drop_count + 1'b1;
      if (load_hist)
        seen_q[slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (load_hist)
      last_q[slot] <= in_seq;
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_accept && !out_drop);

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({out_accept, out_drop}));

  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_seq == 8'h00) |=> out_accept);

  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(in_net ? chk_en_b[in_link] : chk_en_a[in_link])) |=> out_accept);

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_drop && $past(drop_count) != CNT_MAX) |-> drop_count == $past(drop_count) + 1'b1);

  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_drop |-> $stable(drop_count));

endmodule

// File: tb/seqchk_test.sv
module seqchk_test;
  localparam int NL = 8;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_link = '0;
  logic in_net = 1'b0;
  logic [7:0] in_seq = '0;
  logic [NL-1:0] chk_en_a = '1;
  logic [NL-1:0] chk_en_b = '1;
  logic out_valid, out_accept, out_drop;
  logic [CW-1:0] drop_count;

  seqchk #(.NUM_LINKS(NL), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_link(in_link),
    .in_net(in_net), .in_seq(in_seq), .chk_en_a(chk_en_a), .chk_en_b(chk_en_b),
    .out_valid(out_valid), .out_accept(out_accept), .out_drop(out_drop),
    .drop_count(drop_count)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int hist [16];
  bit seen [16];
  int cnt = 0;
  bit pend = 0;
  bit exp_acc = 0;
  string pend_req = "R2";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int succ(input int p, input int k);
    return (p + k - 1) % 255 + 1;
  endfunction

  task automatic step(input bit v, input int link, input int net, input int seq, input string req);
    int ctx;
    bit en;
    @(negedge clk);
    if (pend) begin
      chk(out_valid == 1'b1, "R2", "out_valid", int'(out_valid), 1);
      chk(out_accept == exp_acc, pend_req, "out_accept", int'(out_accept), int'(exp_acc));
      chk(out_drop == !exp_acc, pend_req, "out_drop", int'(out_drop), int'(!exp_acc));
      chk(int'(drop_count) == cnt, "R7", "drop_count", int'(drop_count), cnt);
    end else begin
      chk(out_valid == 1'b0 && out_accept == 1'b0 && out_drop == 1'b0, "R2", "idle outputs",
          int'({out_valid, out_accept, out_drop}), 0);
    end
    in_valid = v;
    in_link = link[2:0];
    in_net = net[0];
    in_seq = seq[7:0];
    pend = v;
    pend_req = req;
    if (v) begin
      ctx = link * 2 + net;
      en = net ? chk_en_b[link] : chk_en_a[link];
      if (!en) exp_acc = 1;
      else if (!seen[ctx] || seq == 0) exp_acc = 1;
      else exp_acc = (seq == succ(hist[ctx], 1)) || (seq == succ(hist[ctx], 2));
      if (exp_acc && en) begin
        hist[ctx] = seq;
        seen[ctx] = 1;
      end
      if (!exp_acc && cnt < CMAX) cnt++;
    end
  endtask

  task automatic do_reset();
    step(0, 0, 0, 0, "R2");
    @(negedge clk);
    rst_n = 1'b0;
    pend = 0;
    @(negedge clk);
    chk(out_valid == 1'b0 && drop_count == '0, "R1", "outputs in reset",
        int'(out_valid) + int'(drop_count), 0);
    rst_n = 1'b1;
    cnt = 0;
    for (int i = 0; i < 16; i++) seen[i] = 0;
  endtask

  function automatic string tag_for(input int p, input int c);
    if (c == 0) return "R5";
    if (c == succ(p, 1) || c == succ(p, 2)) return "R4";
    return "R6";
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    step(0, 0, 0, 0, "R1");

    // R3, R9: first frames on separate pairs
    step(1, 3, 0, 200, "R3");
    step(1, 3, 1, 77, "R9");
    step(1, 3, 0, 201, "R4");
    step(1, 3, 0, 203, "R4");
    step(1, 3, 0, 206, "R6");
    step(1, 3, 0, 204, "R6");
    step(1, 3, 1, 78, "R9");
    step(1, 3, 1, 81, "R9");
    // R5: zero restarts the count
    step(1, 3, 0, 0, "R5");
    step(1, 3, 0, 0, "R5");
    step(1, 3, 0, 2, "R5");
    step(1, 3, 0, 5, "R6");
    // R8: disabled network passes, history untouched
    step(1, 4, 0, 50, "R3");
    step(0, 0, 0, 0, "R8");
    chk_en_a[4] = 1'b0;
    step(1, 4, 0, 7, "R8");
    step(1, 4, 0, 200, "R8");
    step(0, 0, 0, 0, "R8");
    chk_en_a[4] = 1'b1;
    step(1, 4, 0, 51, "R8");
    step(1, 4, 0, 8, "R8");
    step(0, 0, 0, 0, "R8");
    chk_en_b[5] = 1'b0;
    step(1, 5, 1, 9, "R8");
    step(1, 5, 1, 9, "R8");
    step(0, 0, 0, 0, "R8");
    chk_en_b[5] = 1'b1;
    step(1, 5, 1, 33, "R3");
    // R7: saturation
    for (int i = 0; i < CMAX + 5; i++) step(1, 6, 1, (i % 2) ? 100 : 101, "R7");
    step(0, 0, 0, 0, "R7");

    // near-exhaustive sweep: every history value against every candidate
    for (int p = 0; p < 256; p++) begin
      for (int cb = 0; cb < 256; cb += 16) begin
        do_reset();
        for (int ctx = 0; ctx < 16; ctx++) step(1, ctx / 2, ctx % 2, p, "R3");
        for (int ctx = 0; ctx < 16; ctx++)
          step(1, ctx / 2, ctx % 2, cb + ctx, tag_for(p, cb + ctx));
      end
    end
    step(0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, "R2");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule